// File: doc/BRIEF.md
# PHY Delay Register Handshake Port

This block sits between a host bus and a small bank of PHY timing registers. Software reaches every delay setting through one 32-bit control word. The word carries an address, a write byte, a returned read byte, two request flags and a completion flag. Software sets a request flag. The block then runs a request/acknowledge exchange with the PHY-side register bank and raises the completion flag when the access has taken effect. Software clears the request, and the flag falls again. This four-phase exchange is the only path to the delay settings.

The bank holds twelve 8-bit delay values. Nine are per-speed input delays at addresses 0x00 to 0x08. Three are clock and strobe DLL delays at addresses 0x0B to 0x0D. The bank answers each access after a configurable number of cycles, so the host's polling timeout can be exercised against a slow PHY. All values return to zero on reset. Software must reprogram each setting afterwards with one full exchange per setting. The bank's values are also driven out as a flat vector, which feeds the delay lines.

Top module: `phy_dly_port`

## Requirements
- R1: Control word layout: address in bits 5:0, write byte in bits 15:8, read byte in bits 23:16 (read-only), write request in bit 24, read request in bit 25, acknowledge in bit 26 (read-only). Bits 7:6 and 31:27 read 0, and every field reads 0 after reset.
- R2: When the write request is set, the acknowledge rises ACK_LAT+1 clock edges after the edge that stored the control word. By that edge, the write byte has been stored at the addressed delay register.
- R3: The acknowledge stays high while either request bit is held. It falls one clock edge after both request bits are cleared.
- R4: When the read request is set, the acknowledge rises after the same latency as a write. The read-byte field then holds the addressed register's value and keeps it until the next completed read.
- R5: A request that is present while the acknowledge is high starts no access, even with a new address or data. The delay registers keep their values.
- R6: A write to an address outside the implemented set is acknowledged normally but changes no register. A read from such an address returns 0x00.
- R7: If both request bits are set while the block is idle, no access is made and the acknowledge stays low.
- R8: Reset clears all twelve delay registers and the control word. Each register can then be reprogrammed, one full exchange at a time.
- R9: The implemented addresses are 0x00 to 0x08 and 0x0B to 0x0D. They map in ascending order to output slots 0 to 11, each 8 bits wide, with slot k at bits 8k+7:8k of the delay output.
- R10: ACK_LAT must be at least 1, and ACK_LAT+1 must not exceed the host wait budget MAX_WAIT_CYC, which is 2500 cycles by default (about 10 microseconds at 250 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Control word value written by the host |
| bus_rdata | output | 32 | Current control word, including read byte and acknowledge |
| phy_dly_o | output | 96 | Twelve 8-bit delay values, slot 0 in the low byte |

## Verification
All 64 addresses are swept with writes and then reads. A design that decoded the gap at 0x09 to 0x0A or the top of the range wrongly would corrupt a neighbouring slot or return stale bytes. Each access is timed, so an acknowledge that came early, came late, or did not stay high while a request was held is caught. The bench writes a new request while the acknowledge is still high, and sets both request bits at once. A design that did not gate these cases would overwrite a delay or raise the acknowledge when it should not. A reset during operation must zero every slot and still allow a clean reprogramming pass.

// File: rtl/phy_dly_pkg.sv
package phy_dly_pkg;

   // control word field positions
   localparam int ADDR_W    = 6;
   localparam int BYTE_W    = 8;
   localparam int WORD_W    = 32;
   localparam int ADDR_LSB  = 0;
   localparam int WDAT_LSB  = 8;
   localparam int RDAT_LSB  = 16;
   localparam int WREQ_BIT  = 24;
   localparam int RREQ_BIT  = 25;
   localparam int ACK_BIT   = 26;

   // implemented delay slots: a low contiguous run, a gap, then a high run
   localparam int LOW_LAST  = 8;
   localparam int HIGH_FIRST = 11;
   localparam int HIGH_LAST = 13;
   localparam int NUM_SLOTS = (LOW_LAST + 1) + (HIGH_LAST - HIGH_FIRST + 1);
   localparam int SLOT_IW   = $clog2(NUM_SLOTS);
   localparam int DLY_W     = NUM_SLOTS * BYTE_W;

   typedef struct packed {
      logic               hit;
      logic [SLOT_IW-1:0] idx;
   } slot_sel_t;

   function automatic slot_sel_t slot_decode(input logic [ADDR_W-1:0] a);
      slot_sel_t s;
      s.hit = 1'b0;
      s.idx = '0;
      if (int'(a) <= LOW_LAST) begin
         s.hit = 1'b1;
         s.idx = SLOT_IW'(a);
      end else if (int'(a) >= HIGH_FIRST && int'(a) <= HIGH_LAST) begin
         s.hit = 1'b1;
         s.idx = SLOT_IW'(int'(a) - HIGH_FIRST + LOW_LAST + 1);
      end
      return s;
   endfunction

endpackage

// File: rtl/phy_dly_csr.sv
module phy_dly_csr
   import phy_dly_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              ack,
   input  logic [BYTE_W-1:0] rdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] addr,
   output logic [BYTE_W-1:0] wdata,
   output logic              wr_req,
   output logic              rd_req
);

   logic unused_wbits;
   assign unused_wbits = ^{bus_wdata[WORD_W-1:ACK_BIT], bus_wdata[RDAT_LSB+BYTE_W-1:RDAT_LSB],
                           bus_wdata[WDAT_LSB-1:ADDR_LSB+ADDR_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         wdata  <= '0;
         wr_req <= 1'b0;
         rd_req <= 1'b0;
      end else if (bus_we) begin
         addr   <= bus_wdata[ADDR_LSB +: ADDR_W];
         wdata  <= bus_wdata[WDAT_LSB +: BYTE_W];
         wr_req <= bus_wdata[WREQ_BIT];
         rd_req <= bus_wdata[RREQ_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      bus_rdata[ADDR_LSB +: ADDR_W] = addr;
      bus_rdata[WDAT_LSB +: BYTE_W] = wdata;
      bus_rdata[RDAT_LSB +: BYTE_W] = rdata;
      bus_rdata[WREQ_BIT]           = wr_req;
      bus_rdata[RREQ_BIT]           = rd_req;
      bus_rdata[ACK_BIT]            = ack;
   end

endmodule

// File: rtl/phy_dly_seq.sv
module phy_dly_seq
   import phy_dly_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic              done,
   input  logic [BYTE_W-1:0] bank_rdata,
   output logic              start,
   output logic              op_wr,
   output logic              ack,
   output logic [BYTE_W-1:0] rdata
);

   typedef enum logic [1:0] {S_IDLE, S_BUSY, S_ACKD} seq_state_t;

   seq_state_t state_q, state_d;
   logic       op_rd_q;
   logic       legal_req;

   // exactly one request flag: a simultaneous pair is rejected
   assign legal_req = wr_req ^ rd_req;
   assign start     = (state_q == S_IDLE) && legal_req;
   assign op_wr     = wr_req;
   assign ack       = (state_q == S_ACKD);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE: if (legal_req) state_d = S_BUSY;
         S_BUSY: if (done) state_d = S_ACKD;
         S_ACKD: if (!wr_req && !rd_req) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_rd_q <= 1'b0;
         rdata   <= '0;
      end else begin
         state_q <= state_d;
         if (start) op_rd_q <= rd_req;
         if (state_q == S_BUSY && done && op_rd_q) rdata <= bank_rdata;
      end
   end

endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
   import phy_dly_pkg::*;
#(
   parameter int ACK_LAT = 3,
   parameter logic [BYTE_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              done,
   output logic [BYTE_W-1:0] rdata,
   output logic [DLY_W-1:0]  dly
);

   localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] wdat_q;
   slot_sel_t         sel;

   assign sel  = slot_decode(addr_q);
   assign done = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         wr_q   <= 1'b0;
         addr_q <= '0;
         wdat_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(ACK_LAT - 1);
         wr_q   <= op_wr;
         addr_q <= addr;
         wdat_q <= wdata;
      end else if (done) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   logic [BYTE_W-1:0] slot_q [NUM_SLOTS];

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[k] <= RST_VAL;
         else if (done && wr_q && sel.hit && sel.idx == SLOT_IW'(k))
            slot_q[k] <= wdat_q;
      end
      assign dly[k*BYTE_W +: BYTE_W] = slot_q[k];
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_SLOTS; k++)
         if (sel.hit && sel.idx == SLOT_IW'(k)) rdata = slot_q[k];
   end

endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
   import phy_dly_pkg::*;
#(
   parameter int ACK_LAT      = 3,
   parameter int MAX_WAIT_CYC = 2500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [95:0]       phy_dly_o
);

   if (ACK_LAT < 1) begin : g_bad_lat
      $error("ACK_LAT must be at least 1");
   end
   if (ACK_LAT + 1 > MAX_WAIT_CYC) begin : g_bad_budget
      $error("ACK_LAT exceeds the host wait budget");
   end
   if (DLY_W != 96) begin : g_bad_dly
      $error("delay vector width mismatch");
   end

   logic [ADDR_W-1:0] csr_addr;
   logic [BYTE_W-1:0] csr_wdata;
   logic              csr_wr, csr_rd;
   logic              seq_start, seq_op_wr, seq_ack;
   logic [BYTE_W-1:0] seq_rdata, bank_rdata;
   logic              bank_done;

   phy_dly_csr u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .ack       (seq_ack),
      .rdata     (seq_rdata),
      .bus_rdata (bus_rdata),
      .addr      (csr_addr),
      .wdata     (csr_wdata),
      .wr_req    (csr_wr),
      .rd_req    (csr_rd)
   );

   phy_dly_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (csr_wr),
      .rd_req     (csr_rd),
      .done       (bank_done),
      .bank_rdata (bank_rdata),
      .start      (seq_start),
      .op_wr      (seq_op_wr),
      .ack        (seq_ack),
      .rdata      (seq_rdata)
   );

   phy_dly_bank #(.ACK_LAT(ACK_LAT)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .start (seq_start),
      .op_wr (seq_op_wr),
      .addr  (csr_addr),
      .wdata (csr_wdata),
      .done  (bank_done),
      .rdata (bank_rdata),
      .dly   (phy_dly_o)
   );

endmodule

// File: rtl/phy_dly_chk.sv
module phy_dly_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr,
   input logic        rd,
   input logic        ack,
   input logic        start,
   input logic        done,
   input logic [7:0]  rdata,
   input logic [95:0] dly
);

   assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (wr || rd)) |=> ack);

   assert_ack_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !wr && !rd) |=> !ack);

   assert_ack_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(done));

   assert_no_conflict_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !(wr && rd));

   assert_no_start_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !start);

   assert_dly_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> $stable(dly));

   assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> $stable(rdata));

endmodule

bind phy_dly_port phy_dly_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr    (csr_wr),
   .rd    (csr_rd),
   .ack   (seq_ack),
   .start (seq_start),
   .done  (bank_done),
   .rdata (seq_rdata),
   .dly   (phy_dly_o)
);

// File: tb/tb_phy_dly_port.sv
`timescale 1ns/1ps
module tb_phy_dly_port;

   localparam int LAT    = 3;
   localparam int BUDGET = 2500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [95:0] phy_dly_o;

   int errors = 0;
   int checks = 0;
   logic [7:0] model [12];

   always #2 clk = ~clk;

   phy_dly_port #(.ACK_LAT(LAT), .MAX_WAIT_CYC(BUDGET)) dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .phy_dly_o(phy_dly_o)
   );

   function automatic bit is_impl(input int a);
      return (a <= 8) || (a >= 11 && a <= 13);
   endfunction

   function automatic int slot_of(input int a);
      return (a <= 8) ? a : a - 2;
   endfunction

   function automatic logic [31:0] word(input int a, input logic [7:0] d,
                                        input bit w, input bit r);
      return {6'b0, r, w, 8'h00, d, 2'b00, 6'(a)};
   endfunction

   function automatic logic [95:0] model_vec();
      logic [95:0] v;
      for (int k = 0; k < 12; k++) v[k*8 +: 8] = model[k];
      return v;
   endfunction

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [31:0] w);
      @(negedge clk);
      bus_we = 1'b1;
      bus_wdata = w;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // polls for the acknowledge like host software, returns cycles waited
   task automatic poll_ack(output int n);
      n = 0;
      while (bus_rdata[26] !== 1'b1 && n < BUDGET) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_access(input int a, input logic [7:0] d, input bit w,
                            output logic [7:0] rd_byte);
      int n;
      bus_wr(word(a, d, w, !w));
      poll_ack(n);
      chk(w ? "R2 write ack latency" : "R4 read ack latency", 96'(n), 96'(LAT + 1));
      chk("R10 ack within host budget", 96'(n < BUDGET), 96'(1));
      rd_byte = bus_rdata[23:16];
      bus_wr(word(a, d, 1'b0, 1'b0));
      @(negedge clk);
      chk("R3 ack falls after release", 96'(bus_rdata[26]), 96'(0));
   endtask

   initial begin
      logic [7:0] rb;
      logic [95:0] snap;
      for (int k = 0; k < 12; k++) model[k] = 8'h00;
      idle(3);
      chk("R8 reset control word", 96'(bus_rdata), 96'(0));
      chk("R8 reset delay slots", phy_dly_o, 96'(0));
      rst_n = 1'b1;
      idle(2);

      // R1 field layout; reserved and read-only bits written as ones
      bus_wr(32'hF8FF_5CEA);
      chk("R1 field layout", 96'(bus_rdata), 96'(32'h0000_5C2A));
      idle(LAT + 3);
      chk("R1 no ack without request", 96'(bus_rdata[26]), 96'(0));

      // R2 R6 R9 write sweep over every address
      for (int a = 0; a < 64; a++) begin
         logic [7:0] d = 8'((a * 37 + 5) & 8'hFF);
         do_access(a, d, 1'b1, rb);
         if (is_impl(a)) model[slot_of(a)] = d;
         chk(is_impl(a) ? "R9 slot mapping after write" : "R6 unimplemented write",
             phy_dly_o, model_vec());
      end

      // R4 R6 read sweep
      for (int a = 0; a < 64; a++) begin
         do_access(a, 8'h00, 1'b0, rb);
         chk(is_impl(a) ? "R4 read byte" : "R6 unimplemented read 0",
             96'(rb), 96'(is_impl(a) ? model[slot_of(a)] : 8'h00));
         chk("R4 read byte field stable", 96'(bus_rdata[23:16]), 96'(rb));
      end

      // R3 acknowledge held while request held; R5 new request ignored
      bus_wr(word(3, 8'hA5, 1'b1, 1'b0));
      begin int n; poll_ack(n); end
      model[3] = 8'hA5;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R3 ack held", 96'(bus_rdata[26]), 96'(1));
      end
      bus_wr(word(4, 8'h3C, 1'b1, 1'b0));
      idle(LAT + 4);
      chk("R5 request during ack ignored", phy_dly_o, model_vec());
      chk("R3 ack held with new request", 96'(bus_rdata[26]), 96'(1));
      bus_wr(word(4, 8'h3C, 1'b0, 1'b0));
      idle(LAT + 4);
      chk("R5 no late access", phy_dly_o, model_vec());

      // R7 both requests set
      snap = phy_dly_o;
      bus_wr(word(5, 8'h77, 1'b1, 1'b1));
      for (int i = 0; i < LAT + 6; i++) begin
         @(negedge clk);
         chk("R7 no ack on conflict", 96'(bus_rdata[26]), 96'(0));
      end
      chk("R7 no write on conflict", phy_dly_o, snap);
      bus_wr(word(5, 8'h77, 1'b0, 1'b0));
      do_access(5, 8'h00, 1'b0, rb);
      chk("R7 register untouched", 96'(rb), 96'(model[5]));

      // R8 reset mid-operation then reprogram all slots
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 12; k++) model[k] = 8'h00;
      chk("R8 reset clears slots", phy_dly_o, 96'(0));
      chk("R8 reset clears word", 96'(bus_rdata), 96'(0));
      rst_n = 1'b1;
      idle(2);
      for (int a = 0; a < 14; a++) begin
         if (is_impl(a)) begin
            logic [7:0] d = 8'((a * 11 + 8'h60) & 8'hFF);
            do_access(a, d, 1'b1, rb);
            model[slot_of(a)] = d;
         end
      end
      chk("R8 reprogram after reset", phy_dly_o, model_vec());
      for (int a = 0; a < 14; a++) begin
         if (is_impl(a)) begin
            do_access(a, 8'h00, 1'b0, rb);
            chk("R8 readback after reprogram", 96'(rb), 96'(model[slot_of(a)]));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule